// File: doc/BRIEF.md
# Paged Address Extension Mapper

This block turns a 16-bit processor address into a 20-bit physical address through a sixteen-entry page table. The four most significant processor address bits pick one table entry. That 8-bit entry becomes physical bits 19..12, and the low twelve processor address bits pass straight through as the page offset. The result is that sixteen 4 KiB windows can each be pointed at any of 256 physical 4 KiB frames.

Software programs the table with ordinary I/O output cycles. The low address byte selects the table port. The entry number is carried in bits 15..12 of the same I/O cycle, which is where the processor places the top of its upper address register, and the data bus supplies the entry value. The table powers up with arbitrary contents, so the mapper starts in a bypass state that presents an identity map. A second I/O port turns mapping on once the table has been loaded.

Every update is held back while a bus cycle is in progress. It is applied on the first clock on which neither the memory nor the I/O strobe is asserted. As a result, the address of the cycle that performs the write is never disturbed.

Top module: `paged_addr_mapper`

## Requirements
- R1: Reset clears the mapping enable, so directly after reset `phys_addr` equals the processor address zero-extended to 20 bits.
- R2: While mapping is disabled, `phys_addr[19:16]` is 0 and `phys_addr[15:0]` equals `cpu_addr`, whatever the table holds.
- R3: While mapping is enabled, `phys_addr[19:12]` equals the table entry indexed by `cpu_addr[15:12]`, and `phys_addr[11:0]` equals `cpu_addr[11:0]`.
- R4: A table write takes place when `iorq_n` = 0, `wr_n` = 0 and `cpu_addr[7:0]` = 0x40 are all true on the same clock. It stores `cpu_data` into the entry numbered `cpu_addr[15:12]`.
- R5: No table write takes place if any one of the three R4 conditions is missing. This covers an I/O read (`wr_n` = 1) and a memory write (`mreq_n` = 0 with `iorq_n` = 1) to an address whose low byte is 0x40.
- R6: An I/O write to port 0x41 loads `cpu_data[0]` into the mapping enable (1 = mapped, 0 = bypass). No other input changes the enable except reset.
- R7: I/O writes to any port other than 0x40 and 0x41 change neither the table nor the enable.
- R8: A write does not alter `phys_addr` while its bus cycle is still active. The new entry or enable value is applied on the first clock edge where both `iorq_n` and `mreq_n` are 1, and it is visible from the next cycle onward.
- R9: A write strobe held low across several clocks performs exactly one update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock on which the bus strobes are sampled |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 16 | Processor address bus |
| cpu_data | input | 8 | Processor data bus (write data) |
| iorq_n | input | 1 | I/O request strobe, active low |
| mreq_n | input | 1 | Memory request strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| phys_addr | output | 20 | Extended physical address |

## Verification
Translation is tested with every page index and an entry pattern whose values differ from one page to the next, so a mis-indexed entry shows up. The offset bits alternate so that a swapped or dropped offset bit is also caught. The same addresses are applied once in bypass and once mapped, to separate the identity path from the table path. Near-miss write cycles each drop exactly one qualifier: a read, a memory write, and a neighbouring port. Each is followed by a read-back of the targeted page, which shows which qualifier the decoder really depends on. A long write strobe, with the output sampled mid-cycle, separates an immediate update from a deferred one and a single write from a repeated one.

// File: rtl/pam_pkg.sv
package pam_pkg;

   typedef enum logic [1:0] {
      REQ_NONE  = 2'd0,
      REQ_TABLE = 2'd1,
      REQ_CTRL  = 2'd2
   } pam_req_e;

   function automatic int unsigned pam_phys_width(int unsigned cpu_aw,
                                                  int unsigned idx_w,
                                                  int unsigned entry_w);
      return entry_w + (cpu_aw - idx_w);
   endfunction

endpackage

// File: rtl/pam_port_decode.sv
module pam_port_decode
   import pam_pkg::*;
#(
   parameter int unsigned IDX_W      = 4,
   parameter int unsigned PORT_W     = 8,
   parameter int unsigned DATA_W     = 8,
   parameter logic [PORT_W-1:0] TABLE_PORT = 8'h40,
   parameter logic [PORT_W-1:0] CTRL_PORT  = 8'h41
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [IDX_W-1:0]  io_idx,
   input  logic [PORT_W-1:0] io_port,
   input  logic [DATA_W-1:0] io_data,
   input  logic              iorq_n,
   input  logic              wr_n,
   output pam_req_e          req_kind,
   output logic [IDX_W-1:0]  req_idx,
   output logic [DATA_W-1:0] req_data
);

   if (TABLE_PORT == CTRL_PORT) begin : g_port_clash
      $error("pam_port_decode: table and control ports must differ");
   end

   logic io_wr;
   logic io_wr_q;
   logic io_wr_first;

   assign io_wr       = !iorq_n && !wr_n;
   assign io_wr_first = io_wr && !io_wr_q;

   always_ff @(posedge clk) begin
      if (rst) io_wr_q <= 1'b0;
      else     io_wr_q <= io_wr;
   end

   always_comb begin
      req_kind = REQ_NONE;
      if (io_wr_first) begin
         if (io_port == TABLE_PORT)     req_kind = REQ_TABLE;
         else if (io_port == CTRL_PORT) req_kind = REQ_CTRL;
      end
   end

   assign req_idx  = io_idx;
   assign req_data = io_data;

endmodule

// File: rtl/pam_page_table.sv
module pam_page_table
   import pam_pkg::*;
#(
   parameter int unsigned IDX_W   = 4,
   parameter int unsigned ENTRY_W = 8,
   parameter int unsigned DATA_W  = 8,
   localparam int unsigned ENTRIES = 1 << IDX_W
) (
   input  logic               clk,
   input  logic               rst,
   input  pam_req_e           req_kind,
   input  logic [IDX_W-1:0]   req_idx,
   input  logic [DATA_W-1:0]  req_data,
   input  logic               bus_idle,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic [ENTRY_W-1:0] rd_entry,
   output logic               map_en
);

   if (DATA_W != ENTRY_W) begin : g_width_bad
      $error("pam_page_table: data bus width must equal entry width");
   end
   if (ENTRIES > 256) begin : g_depth_bad
      $error("pam_page_table: table deeper than 256 entries");
   end

   // deferred updates: captured during the bus cycle, applied when idle
   logic               tab_pend;
   logic [IDX_W-1:0]   tab_pend_idx;
   logic [ENTRY_W-1:0] tab_pend_val;
   logic               ctl_pend;
   logic               ctl_pend_val;

   always_ff @(posedge clk) begin
      if (rst) begin
         tab_pend     <= 1'b0;
         tab_pend_idx <= '0;
         tab_pend_val <= '0;
      end else if (req_kind == REQ_TABLE) begin
         tab_pend     <= 1'b1;
         tab_pend_idx <= req_idx;
         tab_pend_val <= req_data;
      end else if (bus_idle) begin
         tab_pend     <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ctl_pend     <= 1'b0;
         ctl_pend_val <= 1'b0;
      end else if (req_kind == REQ_CTRL) begin
         ctl_pend     <= 1'b1;
         ctl_pend_val <= req_data[0];
      end else if (bus_idle) begin
         ctl_pend     <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst)                       map_en <= 1'b0;
      else if (bus_idle && ctl_pend) map_en <= ctl_pend_val;
   end

   logic [ENTRY_W-1:0] entry_q [ENTRIES];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      logic hit;
      assign hit = bus_idle && tab_pend && (tab_pend_idx == IDX_W'(e));
      always_ff @(posedge clk) begin
         if (hit) entry_q[e] <= tab_pend_val;
      end
   end

   assign rd_entry = entry_q[rd_idx];

endmodule

// File: rtl/pam_xlate.sv
module pam_xlate #(
   parameter int unsigned CPU_AW  = 16,
   parameter int unsigned IDX_W   = 4,
   parameter int unsigned ENTRY_W = 8,
   localparam int unsigned OFF_W   = CPU_AW - IDX_W,
   localparam int unsigned PHYS_AW = ENTRY_W + OFF_W
) (
   input  logic [CPU_AW-1:0]  cpu_addr,
   input  logic [ENTRY_W-1:0] entry,
   input  logic               map_en,
   output logic [PHYS_AW-1:0] phys_addr
);

   if (ENTRY_W < IDX_W) begin : g_narrow
      $error("pam_xlate: entry narrower than page index");
   end

   logic [PHYS_AW-1:0] ident;

   if (PHYS_AW > CPU_AW) begin : g_pad
      assign ident = {{(PHYS_AW-CPU_AW){1'b0}}, cpu_addr};
   end else begin : g_same
      assign ident = cpu_addr;
   end

   assign phys_addr = map_en ? {entry, cpu_addr[OFF_W-1:0]} : ident;

endmodule

// File: rtl/paged_addr_mapper.sv
module paged_addr_mapper
   import pam_pkg::*;
#(
   parameter int unsigned CPU_AW  = 16,
   parameter int unsigned IDX_W   = 4,
   parameter int unsigned ENTRY_W = 8,
   parameter int unsigned PORT_W  = 8,
   parameter logic [PORT_W-1:0] TABLE_PORT = 8'h40,
   parameter logic [PORT_W-1:0] CTRL_PORT  = 8'h41,
   localparam int unsigned DATA_W  = ENTRY_W,
   localparam int unsigned PHYS_AW = pam_phys_width(CPU_AW, IDX_W, ENTRY_W)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [CPU_AW-1:0]  cpu_addr,
   input  logic [DATA_W-1:0]  cpu_data,
   input  logic               iorq_n,
   input  logic               mreq_n,
   input  logic               wr_n,
   output logic [PHYS_AW-1:0] phys_addr
);

   if (PORT_W + IDX_W > CPU_AW) begin : g_overlap
      $error("paged_addr_mapper: port byte and index field overlap");
   end

   pam_req_e           req_kind;
   logic [IDX_W-1:0]   req_idx;
   logic [DATA_W-1:0]  req_data;
   logic [ENTRY_W-1:0] cur_entry;
   logic               map_en;
   logic               bus_idle;

   assign bus_idle = iorq_n && mreq_n;

   pam_port_decode #(
      .IDX_W(IDX_W), .PORT_W(PORT_W), .DATA_W(DATA_W),
      .TABLE_PORT(TABLE_PORT), .CTRL_PORT(CTRL_PORT)
   ) u_dec (
      .clk(clk), .rst(rst),
      .io_idx(cpu_addr[CPU_AW-1 -: IDX_W]),
      .io_port(cpu_addr[PORT_W-1:0]),
      .io_data(cpu_data),
      .iorq_n(iorq_n), .wr_n(wr_n),
      .req_kind(req_kind), .req_idx(req_idx), .req_data(req_data)
   );

   pam_page_table #(
      .IDX_W(IDX_W), .ENTRY_W(ENTRY_W), .DATA_W(DATA_W)
   ) u_tab (
      .clk(clk), .rst(rst),
      .req_kind(req_kind), .req_idx(req_idx), .req_data(req_data),
      .bus_idle(bus_idle),
      .rd_idx(cpu_addr[CPU_AW-1 -: IDX_W]),
      .rd_entry(cur_entry),
      .map_en(map_en)
   );

   pam_xlate #(
      .CPU_AW(CPU_AW), .IDX_W(IDX_W), .ENTRY_W(ENTRY_W)
   ) u_xl (
      .cpu_addr(cpu_addr), .entry(cur_entry), .map_en(map_en),
      .phys_addr(phys_addr)
   );

endmodule

// File: rtl/pam_checker.sv
module pam_checker #(
   parameter int unsigned CPU_AW  = 16,
   parameter int unsigned PHYS_AW = 20,
   parameter int unsigned IDX_W   = 4
) (
   input logic               clk,
   input logic               rst,
   input logic [CPU_AW-1:0]  cpu_addr,
   input logic               iorq_n,
   input logic               mreq_n,
   input logic [PHYS_AW-1:0] phys_addr,
   input logic               map_en
);

   localparam int unsigned OFF_W = CPU_AW - IDX_W;

   // R2: bypass presents the zero-extended processor address
   p_bypass_ident_r2: assert property (@(posedge clk) disable iff (rst)
      !map_en |-> phys_addr == PHYS_AW'(cpu_addr));

   // R3: mapped mode keeps the page offset
   p_offset_pass_r3: assert property (@(posedge clk) disable iff (rst)
      map_en |-> phys_addr[OFF_W-1:0] == cpu_addr[OFF_W-1:0]);

   // R8: output steady within an active bus cycle on a steady address
   p_hold_in_cycle_r8: assert property (@(posedge clk) disable iff (rst)
      (!iorq_n || !mreq_n) && $past(!iorq_n || !mreq_n) && $stable(cpu_addr)
      |-> $stable(phys_addr));

   // R8: enable only changes after an idle edge
   p_enable_idle_r8: assert property (@(posedge clk) disable iff (rst)
      !$stable(map_en) |-> $past(iorq_n && mreq_n));

   // R1: enable low on the first cycle after reset
   p_reset_clear_r1: assert property (@(posedge clk)
      $past(rst) |-> !map_en);

endmodule

bind paged_addr_mapper pam_checker #(
   .CPU_AW(CPU_AW), .PHYS_AW(PHYS_AW), .IDX_W(IDX_W)
) u_chk (
   .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .iorq_n(iorq_n),
   .mreq_n(mreq_n), .phys_addr(phys_addr), .map_en(map_en)
);

// File: tb/paged_addr_mapper_test.sv
module paged_addr_mapper_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_data = '0;
   logic        iorq_n = 1'b1;
   logic        mreq_n = 1'b1;
   logic        wr_n   = 1'b1;
   logic [19:0] phys_addr;

   int checks = 0;
   int errors = 0;
   logic [7:0] model [16];
   logic       model_en;

   always #5 clk = ~clk;

   paged_addr_mapper uut (
      .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
      .iorq_n(iorq_n), .mreq_n(mreq_n), .wr_n(wr_n), .phys_addr(phys_addr)
   );

   function automatic logic [7:0] pat(int i);
      return 8'((i * 37 + 5) ^ 8'h80);
   endfunction

   function automatic logic [19:0] expect_of(logic [15:0] a);
      if (model_en) return {model[a[15:12]], a[11:0]};
      return {4'h0, a};
   endfunction

   task automatic check(string req, logic [19:0] exp);
      checks++;
      if (phys_addr !== exp) begin
         errors++;
         $display("FAIL %s actual=%05h expected=%05h", req, phys_addr, exp);
      end
   endtask

   task automatic probe(string req, logic [15:0] a);
      @(negedge clk);
      cpu_addr = a; iorq_n = 1'b1; mreq_n = 1'b0; wr_n = 1'b1;
      #2 check(req, expect_of(a));
      @(negedge clk);
      mreq_n = 1'b1;
   endtask

   // generic bus write: hold strobes for 'len' clocks, then one idle clock
   task automatic bus_write(logic io, logic wr, logic [7:0] port,
                            logic [3:0] idx, logic [7:0] d, int len);
      @(negedge clk);
      cpu_addr = {idx, 4'h0, port}; cpu_data = d;
      iorq_n = !io; mreq_n = io; wr_n = !wr;
      for (int k = 0; k < len; k++) @(negedge clk);
      iorq_n = 1'b1; mreq_n = 1'b1; wr_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset();
      probe("R1", 16'hABCD);
      probe("R1", 16'hF00F);
   endtask

   task automatic t_bypass();
      for (int i = 0; i < 16; i++) begin
         bus_write(1'b1, 1'b1, 8'h40, 4'(i), pat(i), 1);
         model[i] = pat(i);
      end
      probe("R2", 16'h5123);
      probe("R2", 16'hFA5A);
   endtask

   task automatic t_enable();
      bus_write(1'b1, 1'b1, 8'h41, 4'h0, 8'h01, 1);
      model_en = 1'b1;
      for (int i = 0; i < 16; i++)
         probe("R3", {4'(i), (i[0] ? 12'hA5A : 12'h5A5)});
   endtask

   task automatic t_near_miss();
      bus_write(1'b1, 1'b0, 8'h40, 4'h6, 8'h00, 1);   // I/O read
      probe("R5", 16'h6123);
      bus_write(1'b0, 1'b1, 8'h40, 4'h6, 8'h00, 1);   // memory write
      probe("R5", 16'h6321);
      bus_write(1'b1, 1'b1, 8'h42, 4'h6, 8'h00, 1);   // neighbour port
      probe("R7", 16'h6777);
      bus_write(1'b1, 1'b1, 8'hC1, 4'h6, 8'h00, 1);   // port differs high bit
      probe("R7", 16'h2001);
   endtask

   task automatic t_deferred();
      probe("R4", 16'h3456);
      @(negedge clk);
      cpu_addr = 16'h3040; cpu_data = 8'h9C;
      iorq_n = 1'b0; wr_n = 1'b0;
      @(negedge clk);
      #1 check("R8", {model[3], 12'h040});
      cpu_data = 8'h11;                                // still low: no 2nd write
      @(negedge clk);
      #1 check("R8", {model[3], 12'h040});
      @(negedge clk);
      iorq_n = 1'b1; wr_n = 1'b1;
      @(negedge clk);
      model[3] = 8'h9C;
      probe("R4", 16'h3456);
      probe("R9", 16'h3FFF);
   endtask

   task automatic t_disable();
      bus_write(1'b1, 1'b1, 8'h41, 4'h0, 8'hFE, 2);
      model_en = 1'b0;
      probe("R6", 16'h3456);
      bus_write(1'b1, 1'b1, 8'h41, 4'h0, 8'h01, 1);
      model_en = 1'b1;
      probe("R6", 16'hE010);
      @(negedge clk) rst = 1'b1;
      @(negedge clk) rst = 1'b0;
      model_en = 1'b0;
      probe("R1", 16'hE010);
   endtask

   initial begin
      model_en = 1'b0;
      for (int i = 0; i < 16; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_bypass();
      t_enable();
      t_near_miss();
      t_deferred();
      t_disable();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #1000000;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule